// File: doc/BRIEF.md
# Dual-Loop Synthesizer Power and Status Control

This block is the digital control core for two frequency-synthesizer loops that share one reference oscillator. Loop 0 is the main loop and loop 1 is the auxiliary loop. For each loop it turns a power-down request into a sequence of states: down, waiting for the reference, and running. From that state it drives the enables and resets of the loop's reference and feedback dividers, the bias of its RF input buffer, and the high-impedance control of its charge pump and phase comparator. The shared oscillator buffer stays on while at least one loop is awake.

A loop leaves power-down in two steps. The request drops first, and the loop then waits for the next reference tick. On that tick both of its dividers leave reset together, so the feedback divider starts in step with the reference divider. Every request and status input is sampled on the rising clock edge.

Each loop also has two open-drain status pins, lock detect and fast-lock switch. Each is modelled as a pull-low enable, so an idle pin reads as logic 1. Lock detect pulls low only while the loop runs and its pump is active in a comparison. The fast-lock switch pulls low only while the loop runs with the fourfold pump current selected. This switch grounds a second loop-filter resistor.

Top module: `synth_pwr_ctrl`

## Requirements
- R1: While rst_n is low, every loop is down: cnt_run=0, cnt_clr=1, inbuf_en=0, cp_hiz=1, ld_pull=0, fl_pull=0, and osc_en=0.
- R2: A loop whose pd_req bit is 1 at a rising edge is down after that edge, whatever state it was in. Down means cnt_run=0, cnt_clr=1, inbuf_en=0 and cp_hiz=1.
- R3: A down loop whose pd_req bit is 0 at an edge enters the waiting state. Waiting means inbuf_en=1, cnt_run=0, cnt_clr=1 and cp_hiz=1. A ref_tick at that same edge does not release it.
- R4: A waiting loop with ref_tick=1 and pd_req=0 at an edge is running after that edge. Running means cnt_run=1, cnt_clr=0 and cp_hiz=0, so both dividers leave reset in the same cycle. A running loop with pd_req=0 stays running, and a waiting loop without ref_tick stays waiting.
- R5: osc_en is 0 exactly when every loop is down. A waiting or running loop keeps it at 1.
- R6: ld_pull of a running loop equals its pump_act bit sampled at the most recent edge. The lock-detect pin reads 0 when pump_act was 1 and reads 1 when the pump was idle.
- R7: ld_pull is 0 for a loop that is down or waiting, whatever pump_act is, so its lock-detect pin reads high.
- R8: fl_pull is 1 only when the loop is running and its fast_sel bit (1 = fourfold pump current) was 1 at the most recent edge. It is 0 when the loop is down or waiting, or when normal current is selected.
- R9: The loops are independent. The state and outputs of one loop depend only on its own pd_req, pump_act and fast_sel bits and the shared ref_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | NUM_LOOPS | Power-down request per loop (bit 0 main, bit 1 auxiliary) |
| ref_tick | input | 1 | One-cycle event at each divided reference edge |
| pump_act | input | NUM_LOOPS | Charge pump active in the current comparison, per loop |
| fast_sel | input | NUM_LOOPS | Fourfold pump current selected, per loop |
| cnt_run | output | NUM_LOOPS | Count enable for the reference and feedback dividers |
| cnt_clr | output | NUM_LOOPS | Hold both dividers of the loop in reset |
| inbuf_en | output | NUM_LOOPS | Bias enable for the loop's RF input buffer |
| osc_en | output | 1 | Enable for the shared reference oscillator buffer |
| cp_hiz | output | NUM_LOOPS | Charge pump and phase comparator outputs high-impedance |
| ld_pull | output | NUM_LOOPS | Lock-detect open-drain pull-low enable |
| fl_pull | output | NUM_LOOPS | Fast-lock switch open-drain pull-low enable |

## Verification
The assertions check several relations on every cycle. A power-down request is followed by a down loop, and a down loop with the request cleared is followed by a waiting loop. Every divider release is preceded by a reference tick seen while waiting. The oscillator enable always agrees with the loops' awake state. Both open-drain pins stay released whenever a loop is not running, and lock detect follows the sampled pump activity. The bench covers what needs a planned sequence. It starts from every combination of per-loop states and applies every input combination, which shows that a tick arriving together with the wake-up does not release the dividers, that a request takes priority over a tick, and that one loop's inputs never disturb the other loop.

// File: rtl/synth_pwr_pkg.sv
package synth_pwr_pkg;

    typedef enum logic [1:0] {
        LP_DOWN = 2'd0,
        LP_WAIT = 2'd1,
        LP_RUN  = 2'd2
    } loop_state_e;

    typedef struct packed {
        loop_state_e state;
    } seq_regs_t;

    typedef struct packed {
        logic act;
        logic fast;
    } stat_regs_t;

endpackage

// File: rtl/loop_seq.sv
module loop_seq
    import synth_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic ref_tick,
    output logic awake_o,
    output logic run_o
);

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            LP_DOWN: nxt_d.state = LP_WAIT;
            LP_WAIT: if (ref_tick) nxt_d.state = LP_RUN;
            LP_RUN:  nxt_d.state = LP_RUN;
            default: nxt_d.state = LP_DOWN;
        endcase
        // a request wins over any wake-up or release in the same cycle
        if (pd) nxt_d.state = LP_DOWN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{state: LP_DOWN};
        else        cur_q <= nxt_d;
    end

    assign awake_o = (cur_q.state != LP_DOWN);
    assign run_o   = (cur_q.state == LP_RUN);

endmodule

// File: rtl/od_status.sv
module od_status
    import synth_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic pump_act,
    input  logic fast_sel,
    output logic ld_pull,
    output logic fl_pull
);

    stat_regs_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.act  = pump_act;
        st_d.fast = fast_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // released (reads high) unless the loop runs
    assign ld_pull = run_i & st_q.act;
    assign fl_pull = run_i & st_q.fast;

endmodule

// File: rtl/osc_gate.sv
module osc_gate #(
    parameter int NUM_LOOPS = 2
) (
    input  logic [NUM_LOOPS-1:0] awake,
    output logic                 osc_en
);

    always_comb begin
        osc_en = 1'b0;
        for (int i = 0; i < NUM_LOOPS; i++) osc_en = osc_en | awake[i];
    end

endmodule

// File: rtl/synth_pwr_ctrl.sv
module synth_pwr_ctrl #(
    parameter int NUM_LOOPS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LOOPS-1:0] pd_req,
    input  logic                 ref_tick,
    input  logic [NUM_LOOPS-1:0] pump_act,
    input  logic [NUM_LOOPS-1:0] fast_sel,
    output logic [NUM_LOOPS-1:0] cnt_run,
    output logic [NUM_LOOPS-1:0] cnt_clr,
    output logic [NUM_LOOPS-1:0] inbuf_en,
    output logic                 osc_en,
    output logic [NUM_LOOPS-1:0] cp_hiz,
    output logic [NUM_LOOPS-1:0] ld_pull,
    output logic [NUM_LOOPS-1:0] fl_pull
);

    logic [NUM_LOOPS-1:0] awake;
    logic [NUM_LOOPS-1:0] run;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        loop_seq u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .pd       (pd_req[g]),
            .ref_tick (ref_tick),
            .awake_o  (awake[g]),
            .run_o    (run[g])
        );

        od_status u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run[g]),
            .pump_act (pump_act[g]),
            .fast_sel (fast_sel[g]),
            .ld_pull  (ld_pull[g]),
            .fl_pull  (fl_pull[g])
        );
    end

    osc_gate #(.NUM_LOOPS(NUM_LOOPS)) u_osc (
        .awake  (awake),
        .osc_en (osc_en)
    );

    assign cnt_run  = run;
    assign cnt_clr  = ~run;
    assign inbuf_en = awake;
    assign cp_hiz   = ~run;

endmodule

// File: rtl/synth_pwr_ctrl_chk.sv
module synth_pwr_ctrl_chk #(
    parameter int NUM_LOOPS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LOOPS-1:0] pd_req,
    input logic                 ref_tick,
    input logic [NUM_LOOPS-1:0] pump_act,
    input logic [NUM_LOOPS-1:0] cnt_run,
    input logic [NUM_LOOPS-1:0] cnt_clr,
    input logic [NUM_LOOPS-1:0] inbuf_en,
    input logic                 osc_en,
    input logic [NUM_LOOPS-1:0] cp_hiz,
    input logic [NUM_LOOPS-1:0] ld_pull,
    input logic [NUM_LOOPS-1:0] fl_pull
);

    assert_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en == (|inbuf_en));

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_chk
        assert_pd_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pd_req[g] |=> (!inbuf_en[g] && cnt_clr[g] && cp_hiz[g]));

        assert_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!pd_req[g] && !inbuf_en[g]) |=> (inbuf_en[g] && !cnt_run[g]));

        assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cnt_run[g]) |-> ($past(ref_tick) && $past(inbuf_en[g])));

        assert_ld_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_run[g] |-> (ld_pull[g] == $past(pump_act[g])));

        assert_ld_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_run[g] |-> !ld_pull[g]);

        assert_fl_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_run[g] |-> !fl_pull[g]);
    end

endmodule

bind synth_pwr_ctrl synth_pwr_ctrl_chk #(.NUM_LOOPS(NUM_LOOPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_req   (pd_req),
    .ref_tick (ref_tick),
    .pump_act (pump_act),
    .cnt_run  (cnt_run),
    .cnt_clr  (cnt_clr),
    .inbuf_en (inbuf_en),
    .osc_en   (osc_en),
    .cp_hiz   (cp_hiz),
    .ld_pull  (ld_pull),
    .fl_pull  (fl_pull)
);

// File: tb/test_synth_pwr_ctrl.sv
module test_synth_pwr_ctrl;

    localparam int NL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] pd_req = '1;
    logic          ref_tick = 1'b0;
    logic [NL-1:0] pump_act = '0;
    logic [NL-1:0] fast_sel = '0;
    logic [NL-1:0] cnt_run, cnt_clr, inbuf_en, cp_hiz, ld_pull, fl_pull;
    logic          osc_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mst [NL];   // model state per loop: 0 down, 1 waiting, 2 running

    always #2 clk = ~clk;

    synth_pwr_ctrl #(.NUM_LOOPS(NL)) i_synth_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .ref_tick(ref_tick),
        .pump_act(pump_act), .fast_sel(fast_sel), .cnt_run(cnt_run),
        .cnt_clr(cnt_clr), .inbuf_en(inbuf_en), .osc_en(osc_en),
        .cp_hiz(cp_hiz), .ld_pull(ld_pull), .fl_pull(fl_pull)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare all outputs against the model after an edge
    task automatic compare(input logic [NL-1:0] act_s, input logic [NL-1:0] fast_s);
        int any_awake = 0;
        for (int i = 0; i < NL; i++) begin
            bit r = (mst[i] == 2);
            bit a = (mst[i] != 0);
            string tag;
            if (mst[i] == 0) tag = "R2"; else if (mst[i] == 1) tag = "R3"; else tag = "R4";
            if (i == 1 && mst[0] != mst[1]) tag = "R9";
            chk(tag, $sformatf("loop%0d run/clr/buf/hiz", i),
                {cnt_run[i], cnt_clr[i], inbuf_en[i], cp_hiz[i]},
                {r, !r, a, !r});
            chk(r ? "R6" : "R7", $sformatf("loop%0d lock-detect pin", i),
                !ld_pull[i], !(r && act_s[i]));
            chk("R8", $sformatf("loop%0d fast-lock pin", i),
                !fl_pull[i], !(r && fast_s[i]));
            if (a) any_awake = 1;
        end
        chk("R5", "osc_en", osc_en, any_awake);
    endtask

    task automatic step(input logic [NL-1:0] pd, input logic rt,
                        input logic [NL-1:0] act, input logic [NL-1:0] fs);
        @(negedge clk);
        pd_req = pd; ref_tick = rt; pump_act = act; fast_sel = fs;
        @(posedge clk);
        for (int i = 0; i < NL; i++) begin
            if (pd[i])             mst[i] = 0;
            else if (mst[i] == 0)  mst[i] = 1;
            else if (mst[i] == 1 && rt) mst[i] = 2;
        end
        #1;
        compare(act, fs);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; pd_req = '1; ref_tick = 1; pump_act = '1; fast_sel = '1;
        #1;
        chk("R1", "reset run/clr", {cnt_run, cnt_clr}, {2'b00, 2'b11});
        chk("R1", "reset buf/osc/hiz", {inbuf_en, osc_en, cp_hiz}, {2'b00, 1'b0, 2'b11});
        chk("R1", "reset pulls", {ld_pull, fl_pull}, 4'b0000);
        for (int i = 0; i < NL; i++) mst[i] = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        for (int s0 = 0; s0 < 3; s0++) begin
            for (int s1 = 0; s1 < 3; s1++) begin
                for (int v = 0; v < 128; v++) begin
                    logic [NL-1:0] keep_dn, run_grp;
                    do_reset();
                    keep_dn = {s1 == 0, s0 == 0};
                    run_grp = {s1 == 2, s0 == 2};
                    step(~run_grp, 1'b0, '0, '0);  // running group wakes
                    step(~run_grp, 1'b1, '1, '0);  // running group released
                    step(keep_dn, 1'b0, '1, '1);   // waiting group wakes
                    // exhaustive input vector from the prepared state pair
                    step(v[1:0], v[2], v[4:3], v[6:5]);
                    // follow-up edge with inputs inverted
                    step(~v[1:0], ~v[2], ~v[4:3], ~v[6:5]);
                end
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule